// File: doc/BRIEF.md
# Wrapping Page Write Buffer

This block stages one page of write data between a serial write engine and a byte-wide backing array of 256 pages of 64 bytes. A sequence opens with a start strobe that carries a 14-bit address. The page number is captured there and stays fixed. The low six bits give the offset where the first byte lands. Each byte strobe after that stores one byte at the current offset and then advances the offset. The offset rolls from 63 back to 0 inside the same page. A long burst therefore overwrites its own earlier bytes instead of spilling into the next page.

A per-location mask records which offsets were loaded in the current sequence. A commit copies only those locations into the array, one per clock, in ascending offset order. All other bytes of the page keep their old contents. An abort discards the sequence without writing. A synchronous memory model with a registered read port is included so that results can be checked. The model holds only the low page bits (32 pages by default), and the page number aliases above that depth.

Top module: `page_wbuf`

## Requirements
- R1: After reset `busy_o` and `done_o` are low and every byte of the array reads 8'hFF.
- R2: A start strobe (not busy) latches the page from `addr_i[13:6]` and the offset from `addr_i[5:0]`, and clears the mask. The first byte after it goes to that offset, and each later byte goes to the next offset.
- R3: The offset wraps from 63 to 0 and the page number never changes during loading, so no byte reaches another page.
- R4: When an offset is loaded more than once in a sequence, the committed value is the last one loaded there.
- R5: A commit writes only the offsets loaded in the current sequence. Every other byte of that page and of all other pages keeps its value.
- R6: An abort (not busy, no start in the same cycle) clears the mask. A later commit then writes nothing.
- R7: A commit with an empty mask does not raise `busy_o` or `done_o` and changes no memory.
- R8: A commit with N loaded offsets holds `busy_o` high for exactly N cycles and writes one byte per cycle in ascending offset order. `done_o` pulses for one cycle right after `busy_o` falls.
- R9: While `busy_o` is high, start, abort, commit and byte strobes are ignored.
- R10: A new start discards the uncommitted bytes of the previous sequence.
- R11: `rd_data_o` shows, one clock later, the byte at `rd_addr_i` as held before that edge. A byte written at an edge can be read at the next edge.
- R12: Input priority when idle is start, then abort, then commit, then byte strobe. A lower-priority strobe in the same cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Open a new sequence |
| addr_i | input | 14 | Page (13:6) and start offset (5:0) for start |
| byte_vld_i | input | 1 | Load one data byte |
| byte_i | input | 8 | Data byte |
| abort_i | input | 1 | Drop the current sequence |
| commit_i | input | 1 | Write loaded bytes to the array |
| rd_addr_i | input | 14 | Array read address |
| rd_data_o | output | 8 | Registered read data |
| busy_o | output | 1 | Commit in progress |
| done_o | output | 1 | One-cycle pulse at end of commit |

## Verification
The bench tries a short burst from a mid-page offset, which separates the loaded bytes from untouched ones in the same page. It then runs a burst of 70 bytes from offset 60, which tells a correct wrap apart from a carry into the next page and shows whether the last value at each offset wins. Abort, an empty commit, a restart before commit, and strobes applied during a drain each show whether stale mask state leaks into memory. A full sweep of the affected pages is read after every commit.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  localparam int unsigned PWB_DATA_W = 8;
  localparam int unsigned PWB_OFFS_W = 6;
  localparam int unsigned PWB_PAGE_W = 8;
  localparam int unsigned PWB_MODEL_PAGE_W = 5;

  typedef enum logic {
    ST_LOAD  = 1'b0,
    ST_DRAIN = 1'b1
  } pwb_state_e;
endpackage

// File: rtl/pwb_loader.sv
module pwb_loader
  import pwb_pkg::*;
#(
  parameter int unsigned OFFS_W = PWB_OFFS_W,
  parameter int unsigned PAGE_W = PWB_PAGE_W,
  localparam int unsigned NBYTES = 1 << OFFS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [PAGE_W-1:0] start_page_i,
  input  logic [OFFS_W-1:0] start_offs_i,
  input  logic              byte_vld_i,
  input  logic              abort_i,
  input  logic              commit_i,
  output logic              load_en_o,
  output logic [OFFS_W-1:0] load_offs_o,
  output logic [PAGE_W-1:0] page_o,
  output logic [NBYTES-1:0] mask_o,
  output logic              mem_we_o,
  output logic [OFFS_W-1:0] drain_idx_o,
  output logic              busy_o,
  output logic              done_o
);
  pwb_state_e        state_q;
  logic [PAGE_W-1:0] page_q;
  logic [OFFS_W-1:0] offs_q;
  logic [NBYTES-1:0] mask_q;
  logic              done_q;
  logic [OFFS_W-1:0] first_idx;
  logic              last_one;
  logic              idle;

  assign idle = (state_q == ST_LOAD);

  // lowest pending offset drains first
  always_comb begin
    first_idx = '0;
    for (int i = NBYTES - 1; i >= 0; i--) begin
      if (mask_q[i]) first_idx = OFFS_W'(i);
    end
  end

  assign last_one = ((mask_q & (mask_q - NBYTES'(1))) == '0);

  assign load_en_o = idle && byte_vld_i && !start_i && !abort_i && !commit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_LOAD;
      page_q  <= '0;
      offs_q  <= '0;
      mask_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (state_q == ST_LOAD) begin
        if (start_i) begin
          page_q <= start_page_i;
          offs_q <= start_offs_i;
          mask_q <= '0;
        end else if (abort_i) begin
          mask_q <= '0;
        end else if (commit_i) begin
          if (|mask_q) state_q <= ST_DRAIN;
        end else if (byte_vld_i) begin
          mask_q[offs_q] <= 1'b1;
          offs_q         <= offs_q + OFFS_W'(1);
        end
      end else begin
        mask_q[first_idx] <= 1'b0;
        if (last_one) begin
          state_q <= ST_LOAD;
          done_q  <= 1'b1;
        end
      end
    end
  end

  assign load_offs_o = offs_q;
  assign page_o      = page_q;
  assign mask_o      = mask_q;
  assign mem_we_o    = (state_q == ST_DRAIN);
  assign drain_idx_o = first_idx;
  assign busy_o      = (state_q == ST_DRAIN);
  assign done_o      = done_q;
endmodule

// File: rtl/pwb_store.sv
module pwb_store #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OFFS_W = 6,
  localparam int unsigned NBYTES = 1 << OFFS_W
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [OFFS_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [OFFS_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] buf_q [NBYTES];

  always_ff @(posedge clk_i) begin
    if (we_i) buf_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = buf_q[raddr_i];
endmodule

// File: rtl/pwb_mem_model.sv
module pwb_mem_model #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned AW     = 11,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] arr_q [DEPTH] = '{default: '1};
  logic [DATA_W-1:0] rdata_q = '1;

  always_ff @(posedge clk_i) begin
    rdata_q <= arr_q[raddr_i];
    if (we_i) arr_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/page_wbuf.sv
module page_wbuf
  import pwb_pkg::*;
#(
  parameter int unsigned DATA_W       = PWB_DATA_W,
  parameter int unsigned OFFS_W       = PWB_OFFS_W,
  parameter int unsigned PAGE_W       = PWB_PAGE_W,
  parameter int unsigned MODEL_PAGE_W = PWB_MODEL_PAGE_W,
  localparam int unsigned ADDR_W = PAGE_W + OFFS_W,
  localparam int unsigned MEM_AW = MODEL_PAGE_W + OFFS_W,
  localparam int unsigned NBYTES = 1 << OFFS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              byte_vld_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              abort_i,
  input  logic              commit_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              busy_o,
  output logic              done_o
);
  logic              load_en;
  logic [OFFS_W-1:0] load_offs;
  logic [PAGE_W-1:0] page_q;
  logic [NBYTES-1:0] mask_q;
  logic              mem_we;
  logic [OFFS_W-1:0] drain_idx;
  logic [DATA_W-1:0] drain_data;
  logic [MEM_AW-1:0] mem_waddr;

  pwb_loader #(.OFFS_W(OFFS_W), .PAGE_W(PAGE_W)) u_loader (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .start_page_i (addr_i[ADDR_W-1:OFFS_W]),
    .start_offs_i (addr_i[OFFS_W-1:0]),
    .byte_vld_i   (byte_vld_i),
    .abort_i      (abort_i),
    .commit_i     (commit_i),
    .load_en_o    (load_en),
    .load_offs_o  (load_offs),
    .page_o       (page_q),
    .mask_o       (mask_q),
    .mem_we_o     (mem_we),
    .drain_idx_o  (drain_idx),
    .busy_o       (busy_o),
    .done_o       (done_o)
  );

  pwb_store #(.DATA_W(DATA_W), .OFFS_W(OFFS_W)) u_store (
    .clk_i   (clk_i),
    .we_i    (load_en),
    .waddr_i (load_offs),
    .wdata_i (byte_i),
    .raddr_i (drain_idx),
    .rdata_o (drain_data)
  );

  assign mem_waddr = {page_q[MODEL_PAGE_W-1:0], drain_idx};

  generate
    if (MODEL_PAGE_W < PAGE_W) begin : g_alias
      logic unused_hi;
      assign unused_hi = ^{page_q[PAGE_W-1:MODEL_PAGE_W], rd_addr_i[ADDR_W-1:MEM_AW]};
    end
  endgenerate

  pwb_mem_model #(.DATA_W(DATA_W), .AW(MEM_AW)) u_mem (
    .clk_i   (clk_i),
    .we_i    (mem_we),
    .waddr_i (mem_waddr),
    .wdata_i (drain_data),
    .raddr_i (rd_addr_i[MEM_AW-1:0]),
    .rdata_o (rd_data_o)
  );
endmodule

// File: rtl/page_wbuf_chk.sv
module page_wbuf_chk #(
  parameter int unsigned NBYTES = 64,
  parameter int unsigned PAGE_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              abort_i,
  input logic              commit_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              mem_we,
  input logic [NBYTES-1:0] mask,
  input logic [PAGE_W-1:0] page
);
  // R8
  a_r8_done_after_drain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(busy_o) && !busy_o));
  a_r8_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r8_write_each_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (mem_we && (mask != '0)));
  a_r8_mask_drops_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (($countones(mask) + 1) == $countones($past(mask))));
  // R7
  a_r7_empty_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && commit_i && !start_i && !abort_i && (mask == '0)) |=> (!busy_o && !done_o));
  a_r7_no_write_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_we);
  // R6
  a_r6_abort_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && abort_i && !start_i) |=> ((mask == '0) && !busy_o));
  // R3, R9
  a_r3_page_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(page));
  a_r9_page_hold_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(page));
endmodule

bind page_wbuf page_wbuf_chk #(.NBYTES(NBYTES), .PAGE_W(PAGE_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .abort_i  (abort_i),
  .commit_i (commit_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .mem_we   (mem_we),
  .mask     (mask_q),
  .page     (page_q)
);

// File: tb/page_wbuf_tb_top.sv
module page_wbuf_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_BYTES  = 2048;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [13:0] addr = '0;
  logic        bvld = 1'b0;
  logic [7:0]  bdat = '0;
  logic        abort = 1'b0;
  logic        commit = 1'b0;
  logic [13:0] rd_addr = '0;
  logic [7:0]  rd_data;
  logic        busy;
  logic        done;

  always #(CLK_PERIOD / 2) clk = ~clk;

  page_wbuf dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .start_i    (start),
    .addr_i     (addr),
    .byte_vld_i (bvld),
    .byte_i     (bdat),
    .abort_i    (abort),
    .commit_i   (commit),
    .rd_addr_i  (rd_addr),
    .rd_data_o  (rd_data),
    .busy_o     (busy),
    .done_o     (done)
  );

  // behavioural reference
  byte unsigned mem_m [MEM_BYTES];
  byte unsigned buf_m [64];
  bit          loaded_m [64];
  int          page_m = 0;
  int          offs_m = 0;
  int          drain_q[$];
  bit          busy_m = 0;
  bit          done_m = 0;
  byte unsigned rd_m = 8'hFF;
  bit          chk_en = 0;

  int    n_vec = 0;
  int    n_bad = 0;
  string cur_req = "R1";

  initial begin
    foreach (mem_m[i]) mem_m[i] = 8'hFF;
    foreach (loaded_m[i]) loaded_m[i] = 0;
  end

  function automatic bit any_loaded();
    foreach (loaded_m[i]) if (loaded_m[i]) return 1;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (rst_n) begin
      rd_m   = mem_m[int'(rd_addr) % MEM_BYTES];
      done_m = 0;
      if (busy_m) begin
        int o;
        o = drain_q.pop_front();
        mem_m[(page_m * 64 + o) % MEM_BYTES] = buf_m[o];
        loaded_m[o] = 0;
        if (drain_q.size() == 0) begin
          busy_m = 0;
          done_m = 1;
        end
      end else if (start) begin
        page_m = int'(addr) / 64;
        offs_m = int'(addr) % 64;
        foreach (loaded_m[i]) loaded_m[i] = 0;
      end else if (abort) begin
        foreach (loaded_m[i]) loaded_m[i] = 0;
      end else if (commit) begin
        if (any_loaded()) begin
          for (int i = 0; i < 64; i++) if (loaded_m[i]) drain_q.push_back(i);
          busy_m = 1;
        end
      end else if (bvld) begin
        buf_m[offs_m]    = bdat;
        loaded_m[offs_m] = 1;
        offs_m = (offs_m + 1) % 64;
      end
      chk_en = 1;
    end
  end

  task automatic check(string what, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chk_en) begin
      check("busy_o", int'(busy), int'(busy_m));
      check("done_o", int'(done), int'(done_m));
      check("rd_data_o", int'(rd_data), int'(rd_m));
    end
  end

  task automatic drive(bit s, bit a, bit c, bit b, byte unsigned d, int ad);
    @(negedge clk);
    start = s; abort = a; commit = c; bvld = b; bdat = d; addr = 14'(ad);
  endtask

  task automatic idle();
    drive(0, 0, 0, 0, 0, 0);
  endtask

  task automatic wait_drain();
    string keep;
    keep = cur_req;
    cur_req = "R8";
    for (int i = 0; i < 80; i++) begin
      idle();
      if (!busy && !done) break;
    end
    idle();
    cur_req = keep;
  endtask

  task automatic sweep(int pg);
    string keep;
    keep = cur_req;
    cur_req = {keep, "/R11"};
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      rd_addr = 14'(pg * 64 + i);
    end
    idle();
    idle();
    cur_req = keep;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R1";
    check("busy_o in reset", int'(busy), 0);
    check("done_o in reset", int'(done), 0);
    rst_n = 1'b1;
    idle();
    sweep(0);

    // R2, R5: short burst from offset 10 of page 3
    cur_req = "R2";
    drive(1, 0, 0, 0, 0, 3 * 64 + 10);
    for (int i = 0; i < 5; i++) drive(0, 0, 0, 1, 8'h10 + i, 0);
    cur_req = "R5";
    drive(0, 0, 1, 0, 0, 0);
    wait_drain();
    sweep(3);
    sweep(2);

    // R3, R4: 70 bytes from offset 60 wrap and overwrite
    cur_req = "R3";
    drive(1, 0, 0, 0, 0, 7 * 64 + 60);
    for (int i = 0; i < 70; i++) drive(0, 0, 0, 1, 8'(i * 3 + 1), 0);
    cur_req = "R4";
    drive(0, 0, 1, 0, 0, 0);
    wait_drain();
    sweep(7);
    cur_req = "R3";
    sweep(8);

    // R6: abort then commit
    cur_req = "R6";
    drive(1, 0, 0, 0, 0, 3 * 64);
    for (int i = 0; i < 4; i++) drive(0, 0, 0, 1, 8'hA0 + i, 0);
    drive(0, 1, 0, 0, 0, 0);
    drive(0, 0, 1, 0, 0, 0);
    idle(); idle();
    sweep(3);

    // R7: empty commit
    cur_req = "R7";
    drive(1, 0, 0, 0, 0, 5 * 64);
    drive(0, 0, 1, 0, 0, 0);
    idle(); idle();
    sweep(5);

    // R9: strobes during drain
    cur_req = "R9";
    drive(1, 0, 0, 0, 0, 9 * 64 + 30);
    for (int i = 0; i < 6; i++) drive(0, 0, 0, 1, 8'h50 + i, 0);
    drive(0, 0, 1, 0, 0, 0);
    drive(0, 0, 0, 1, 8'hEE, 0);
    drive(1, 0, 0, 0, 0, 9 * 64);
    drive(0, 1, 0, 0, 0, 0);
    drive(0, 0, 1, 0, 0, 0);
    wait_drain();
    drive(0, 0, 0, 1, 8'h77, 0);
    drive(0, 0, 1, 0, 0, 0);
    wait_drain();
    sweep(9);

    // R10: restart drops earlier bytes
    cur_req = "R10";
    drive(1, 0, 0, 0, 0, 11 * 64 + 2);
    for (int i = 0; i < 3; i++) drive(0, 0, 0, 1, 8'hC0 + i, 0);
    drive(1, 0, 0, 0, 0, 11 * 64 + 40);
    for (int i = 0; i < 2; i++) drive(0, 0, 0, 1, 8'hD0 + i, 0);
    drive(0, 0, 1, 0, 0, 0);
    wait_drain();
    sweep(11);

    // R12: priority within one cycle
    cur_req = "R12";
    drive(1, 0, 0, 1, 8'h99, 12 * 64 + 5);
    drive(0, 1, 1, 1, 8'h98, 0);
    drive(0, 0, 0, 1, 8'h31, 0);
    drive(0, 0, 1, 1, 8'h32, 0);
    wait_drain();
    sweep(12);

    // R5: partial rewrite of page 3 keeps earlier bytes
    cur_req = "R5";
    drive(1, 0, 0, 0, 0, 3 * 64 + 12);
    drive(0, 0, 0, 1, 8'h5A, 0);
    drive(0, 0, 1, 0, 0, 0);
    wait_drain();
    sweep(3);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule